// File: doc/BRIEF.md
# I2C Register Interface for a Real-Time Clock

This block connects the 16-entry register file of a real-time clock to a two-wire I2C bus as a slave. It oversamples SCL and SDA with the system clock, passes each line through a two-flop synchroniser and a glitch filter, and decodes start, repeated-start and stop conditions from SDA edges seen while SCL is high. It answers to one fixed 7-bit device address. It drives SDA only through an open-drain output enable.

After a write-addressed header, the first byte is a command byte. Its upper nibble loads the register pointer and its lower nibble is a format field, which is presented on an output. Further bytes are written into the register file at the pointer, and the pointer advances after every byte. A read-addressed header streams bytes out from the pointer in the same way. When no command byte has been sent since the last stop, reads begin at register Fh. The master's not-acknowledge ends a read.

For as long as a bus transaction is open, the block tells the timekeeping counters to hold their one-second carry. A carry that arrives in that window is kept as pending and is released when the stop condition is seen, so a multi-byte read always returns a coherent time.

Top module: `rtc_i2c_regif`

## Requirements
- R1: After reset, sda_oe, carry_hold, sec_inc and reg_wr_en are 0 and reg_addr is 4'hF.
- R2: The first byte after a start carries the 7-bit device address (default 7'b0110010, MSB first) followed by a direction bit (1 = read, 0 = write). On a match the block pulls SDA low during the ninth SCL clock. Any other address gets no acknowledge and causes no register write until the next start.
- R3: The byte after a write-addressed header is the command byte. Bits 7:4 load the pointer, bits 3:0 appear on fmt_o, and the byte is acknowledged.
- R4: Each following written byte is acknowledged and produces a single-cycle reg_wr_en with reg_addr equal to the pointer. The pointer then increments, wrapping from Fh to 0h.
- R5: After a read-addressed header, bytes are sent MSB first starting at the pointer. The pointer increments after each byte, and the next byte is fetched after the master acknowledges.
- R6: A master not-acknowledge on a read byte ends the transfer. The block keeps SDA released until the next start.
- R7: The pointer returns to Fh at every stop. A read that follows the address directly therefore starts at register Fh.
- R8: A repeated start keeps the pointer and accepts a new address byte.
- R9: carry_hold is 1 from a start condition until the following stop condition. SDA is never driven while it is 0.
- R10: A sec_tick pulse while carry_hold is 0 gives a sec_inc pulse one clock later. While carry_hold is 1, sec_inc stays 0 and at most one tick is remembered. That tick is issued as a single sec_inc one clock after the stop is detected.
- R11: Pulses on SCL or SDA shorter than FILT_LEN system clocks do not change the decoded bus state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL line |
| sda_i | input | 1 | Raw SDA line |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_addr | output | 4 | Register pointer, used for both reads and writes |
| reg_wr_en | output | 1 | Write strobe for the register file |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data at reg_addr, same cycle |
| fmt_o | output | 4 | Format field from the last command byte |
| sec_tick | input | 1 | One-second carry from the prescaler |
| sec_inc | output | 1 | Carry forwarded to the time counters |
| carry_hold | output | 1 | High while a transaction is open |

## Verification
The bench builds the block with its default address 7'b0110010 and FILT_LEN = 3. With a quarter-bit of ten system clocks, injected SCL and SDA spikes of one and two clocks fall just inside the filter's rejection window, while normal edges pass. The four-bit pointer puts the Fh-to-0h wrap within reach of short random bursts that start near the top of the map. Seeded random pointers, burst lengths and data are mixed with directed cases for direct reads, foreign addresses and carries held across a transaction.

// File: rtl/rtc_i2c_regif.sv
module rtc_i2c_regif #(
  parameter logic [6:0] DEV_ADDR = 7'b0110010,
  parameter int FILT_LEN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [3:0] reg_addr,
  output logic       reg_wr_en,
  output logic [7:0] reg_wdata,
  input  logic [7:0] reg_rdata,
  output logic [3:0] fmt_o,
  input  logic       sec_tick,
  output logic       sec_inc,
  output logic       carry_hold
);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_CMD, S_CACK, S_WR, S_WACK, S_RD, S_MACK
  } st_t;

  logic [1:0] scl_s, sda_s;
  logic [FILT_LEN-1:0] scl_h, sda_h;
  logic scl_f, sda_f, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1;
      scl_h <= '1; sda_h <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1;
      scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_h <= {scl_h[FILT_LEN-2:0], scl_s[1]};
      sda_h <= {sda_h[FILT_LEN-2:0], sda_s[1]};
      if (&scl_h) scl_f <= 1'b1; else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h) sda_f <= 1'b1; else if (~|sda_h) sda_f <= 1'b0;
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  wire scl_rise = scl_f & ~scl_d;
  wire scl_fall = ~scl_f & scl_d;
  wire bus_start = scl_f & scl_d & sda_d & ~sda_f;
  wire bus_stop  = scl_f & scl_d & ~sda_d & sda_f;

  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic [3:0] ptr;
  logic       rw, mnack, pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; ptr <= 4'hF; fmt_o <= '0;
      rw <= 1'b0; mnack <= 1'b0; pend <= 1'b0; carry_hold <= 1'b0;
      sec_inc <= 1'b0; reg_wr_en <= 1'b0; reg_wdata <= '0;
    end else begin
      reg_wr_en <= 1'b0;
      if (reg_wr_en) ptr <= ptr + 4'd1;
      sec_inc <= sec_tick & ~carry_hold;
      if (sec_tick & carry_hold) pend <= 1'b1;
      if (bus_stop) begin
        st <= S_IDLE;
        carry_hold <= 1'b0;
        ptr <= 4'hF;
        sec_inc <= pend | sec_tick;
        pend <= 1'b0;
      end else if (bus_start) begin
        st <= S_ADDR;
        cnt <= '0;
        carry_hold <= 1'b1;
      end else begin
        case (st)
          S_ADDR, S_CMD, S_WR: begin
            if (scl_rise && cnt != 4'd8) begin
              sh <= {sh[6:0], sda_f};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (st == S_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  rw <= sh[0];
                  st <= S_AACK;
                end else st <= S_IDLE;
              end else if (st == S_CMD) begin
                ptr <= sh[7:4];
                fmt_o <= sh[3:0];
                st <= S_CACK;
              end else begin
                reg_wr_en <= 1'b1;
                reg_wdata <= sh;
                st <= S_WACK;
              end
            end
          end
          S_AACK: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              st <= S_RD;
              sh <= reg_rdata;
            end else st <= S_CMD;
          end
          S_CACK, S_WACK: if (scl_fall) begin
            cnt <= '0;
            st <= S_WR;
          end
          S_RD: if (scl_fall) begin
            sh <= {sh[6:0], 1'b0};
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7) begin
              st <= S_MACK;
              ptr <= ptr + 4'd1;
            end
          end
          S_MACK: begin
            if (scl_rise) mnack <= sda_f;
            if (scl_fall) begin
              cnt <= '0;
              if (mnack) st <= S_IDLE;
              else begin
                st <= S_RD;
                sh <= reg_rdata;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign reg_addr = ptr;
  assign sda_oe = (st == S_AACK) | (st == S_CACK) | (st == S_WACK) |
                  ((st == S_RD) & ~sh[7]);

endmodule

// File: rtl/rtc_i2c_regif_chk.sv
module rtc_i2c_regif_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       carry_hold,
  input logic       sec_inc,
  input logic       reg_wr_en,
  input logic [3:0] reg_addr
);

  a_r9_drive_inside_txn: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> carry_hold);

  a_r10_quiet_while_held: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_hold && $past(carry_hold)) |-> !sec_inc);

  a_r4_single_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> reg_addr == 4'($past(reg_addr) + 4'd1));

  a_r7_ptr_home_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(carry_hold) |-> reg_addr == 4'hF);

endmodule

bind rtc_i2c_regif rtc_i2c_regif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .carry_hold(carry_hold),
  .sec_inc(sec_inc), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr)
);

// File: tb/sim_rtc_i2c_regif.sv
`timescale 1ns/1ps
module sim_rtc_i2c_regif;
  localparam logic [6:0] DEV = 7'b0110010;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1, sec_tick = 1'b0;
  logic sda_oe, reg_wr_en, sec_inc, carry_hold;
  logic [3:0] reg_addr, fmt_o;
  logic [7:0] reg_wdata, reg_rdata;
  logic sda_bus;
  assign sda_bus = m_sda & ~sda_oe;

  rtc_i2c_regif u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fmt_o(fmt_o), .sec_tick(sec_tick),
    .sec_inc(sec_inc), .carry_hold(carry_hold)
  );

  logic [7:0] mem [16];
  logic [7:0] expm [16];
  int wr_cnt = 0, inc_cnt = 0;
  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) begin
    if (reg_wr_en) begin mem[reg_addr] <= reg_wdata; wr_cnt <= wr_cnt + 1; end
    if (sec_inc) inc_cnt <= inc_cnt + 1;
  end

  int total = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] nxt(input logic [3:0] p);
    return p + 4'd1;
  endfunction

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic i2c_start(); m_sda = 1; wq(); m_scl = 1; wq(); m_sda = 0; wq(); m_scl = 0; wq(); endtask
  task automatic i2c_stop(); m_sda = 0; wq(); m_scl = 1; wq(); m_sda = 1; wq(); endtask
  task automatic send_bit(input logic b, input bit glitch);
    m_sda = b; wq(); m_scl = 1; wq();
    if (glitch) begin
      @(negedge clk) m_scl = 0; @(negedge clk) m_scl = 1;
      repeat (2) @(negedge clk); m_sda = ~b; repeat (2) @(negedge clk); m_sda = b;
      repeat (Q-6) @(negedge clk);
    end else wq();
    m_scl = 0; wq();
  endtask
  task automatic get_bit(output logic b);
    m_sda = 1; wq(); m_scl = 1; wq(); b = sda_bus; wq(); m_scl = 0; wq();
  endtask
  task automatic wr_byte(input logic [7:0] d, input bit glitch, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i], glitch && i == 3);
    get_bit(b);
    ack = !b;
  endtask
  task automatic rd_byte(input bit mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    send_bit(!mack, 0);
  endtask

  initial begin
    bit ack;
    logic [7:0] d;
    logic [3:0] p, f;
    int n, w0, c0;
    void'($urandom(32'h2025));
    for (int i = 0; i < 16; i++) begin mem[i] = 8'(i * 17) ^ 8'h5A; expm[i] = mem[i]; end
    repeat (5) @(negedge clk);
    chk(sda_oe == 0 && carry_hold == 0 && sec_inc == 0 && reg_wr_en == 0, "R1 idle outputs",
        {sda_oe, carry_hold, sec_inc, reg_wr_en}, 0);
    chk(reg_addr == 4'hF, "R1 pointer", reg_addr, 4'hF);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // direct read from Fh, wrap to 0h, NACK releases
    i2c_start();
    chk(carry_hold == 1, "R9 hold after start", carry_hold, 1);
    wr_byte({DEV, 1'b1}, 0, ack);
    chk(ack, "R2 address ack", ack, 1);
    rd_byte(1, d);
    chk(d == expm[15], "R7 first read at Fh", d, expm[15]);
    rd_byte(0, d);
    chk(d == expm[0], "R5 read wraps to 0h", d, expm[0]);
    chk(sda_oe == 0 && sda_bus == 1, "R6 released after nack", sda_oe, 0);
    repeat (3) begin
      logic b;
      get_bit(b);
      chk(b == 1, "R6 stays released", b, 1);
    end
    i2c_stop();
    chk(carry_hold == 0, "R9 hold cleared at stop", carry_hold, 1'b0);
    chk(reg_addr == 4'hF, "R7 pointer home after stop", reg_addr, 4'hF);

    // random bursts: write then read back through repeated starts
    for (int it = 0; it < 6; it++) begin
      p = (it < 2) ? 4'hE : 4'($urandom_range(0, 15));
      f = 4'($urandom_range(0, 15));
      n = $urandom_range(1, 5);
      i2c_start();
      wr_byte({DEV, 1'b0}, 0, ack);
      chk(ack, "R2 write address ack", ack, 1);
      wr_byte({p, f}, 0, ack);
      chk(ack && fmt_o == f, "R3 command ack and format", fmt_o, f);
      begin
        logic [3:0] q = p;
        for (int k = 0; k < n; k++) begin
          d = 8'($urandom);
          wr_byte(d, 0, ack);
          chk(ack, "R4 data ack", ack, 1);
          expm[q] = d;
          q = nxt(q);
        end
      end
      i2c_start();
      wr_byte({DEV, 1'b0}, 0, ack);
      wr_byte({p, 4'h0}, 0, ack);
      i2c_start();
      wr_byte({DEV, 1'b1}, 0, ack);
      chk(ack && carry_hold, "R8 repeated start accepted", ack, 1);
      begin
        logic [3:0] q = p;
        for (int k = 0; k < n; k++) begin
          rd_byte(k != n - 1, d);
          chk(d == expm[q], "R4 R5 readback", d, expm[q]);
          q = nxt(q);
        end
      end
      i2c_stop();
    end

    // foreign address
    w0 = wr_cnt;
    i2c_start();
    wr_byte({7'b1010011, 1'b0}, 0, ack);
    chk(!ack, "R2 foreign address not acked", ack, 0);
    wr_byte(8'h20, 0, ack);
    wr_byte(8'hC3, 0, ack);
    chk(!ack, "R2 foreign data not acked", ack, 0);
    i2c_stop();
    chk(wr_cnt == w0, "R2 no write on foreign address", wr_cnt - w0, 0);

    // carry outside and inside a transaction
    repeat (3) @(negedge clk);
    c0 = inc_cnt;
    sec_tick = 1; @(negedge clk); sec_tick = 0;
    chk(sec_inc == 1, "R10 pass-through carry", sec_inc, 1);
    @(negedge clk);
    chk(sec_inc == 0, "R10 single pulse", sec_inc, 0);
    c0 = inc_cnt;
    i2c_start();
    sec_tick = 1; @(negedge clk); sec_tick = 0;
    wq();
    sec_tick = 1; @(negedge clk); sec_tick = 0;
    wq();
    chk(inc_cnt == c0, "R10 carry held while open", inc_cnt - c0, 0);
    i2c_stop();
    repeat (3) @(negedge clk);
    chk(inc_cnt == c0 + 1, "R10 one carry released at stop", inc_cnt - c0, 1);

    // glitch rejection
    i2c_start();
    wr_byte({DEV, 1'b0}, 0, ack);
    wr_byte({4'h3, 4'h0}, 0, ack);
    wr_byte(8'hA5, 1, ack);
    chk(ack, "R11 glitched byte acked", ack, 1);
    expm[3] = 8'hA5;
    i2c_stop();
    chk(mem[3] == 8'hA5, "R11 glitched byte stored", mem[3], 8'hA5);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule